// File: doc/BRIEF.md
# Oscillator Sub-Band Search Controller

This block chooses the coarse frequency band of a charge-pump PLL whose oscillator has eight overlapping sub-bands. It opens the loop, walks a one-hot select across eleven ladder references, and samples two comparators that judge the loop control voltage against the selected level. After the walk it looks at the result taken at a low window level and at a high window level. It then moves a 3-bit band code one step up or down, or leaves it alone. Then it closes the loop and waits a settle time before it walks again. When a walk finds the voltage inside the window, it raises a lock flag and holds the code.

The comparators, the reference ladder and the current DAC that the band code drives sit outside the block. A power-down input forces the code to zero and stops all activity. When power-down is released, the block waits out a programmable initialization interval before its first walk. A start pulse after lock or after an out-of-range stop searches again from the code it already holds, for example after the divider ratio has changed.

Top module: `band_sel_ctrl`

## Requirements
- R1: While `pwr_dn` is high, `band_code` is 0. From the second cycle of power-down onwards `cp_break`, `locked`, `out_of_range` and `level_sel` are also all 0. After reset with `pwr_dn` high, every output is 0.
- R2: After the first rising edge that samples `pwr_dn` low, `cp_break` first goes high exactly `init_cycles` + 2 clock cycles later.
- R3: A walk drives `level_sel` one-hot through bit 0 up to bit 10 on 11 consecutive cycles, one bit per cycle. `cp_break` is high throughout the walk and for one decision cycle after it, during which `level_sel` is 0.
- R4: `cmp_hi` = 1 means the control voltage is above the selected level, and `cmp_lo` = 1 means it is below it. If `cmp_hi` was 1 at step 8, the code rises by one. Otherwise, if `cmp_lo` was 1 at step 2, the code falls by one. The code changes by at most one per walk, and a rise wins when both are seen.
- R5: Comparator results taken at steps other than 2 (`cmp_lo`) and 8 (`cmp_hi`) have no effect on the decision.
- R6: The code changes only on the edge where `cp_break` falls after a decision. `cp_break` then stays low for exactly `settle_cycles` + 1 cycles before the next walk.
- R7: When a walk finds neither condition, `locked` goes high on the cycle after the decision. While locked, `cp_break` is low, `level_sel` is 0 and `band_code` holds.
- R8: A step requested above code 7 or below code 0 leaves the code unchanged and raises `out_of_range`. No further walk starts, and `locked` and `out_of_range` are never high together.
- R9: A `start` pulse while locked or out of range begins a new walk on the next cycle, from the held code. On that cycle `locked` and `out_of_range` are 0.
- R10: Power-down in the middle of a search aborts it. The code reached so far is kept. On release the search resumes from that code after a fresh initialization interval.
- R11: The reset value of the held band code is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down request; gates the code to zero |
| start | input | 1 | Restart search pulse (honoured when locked or out of range) |
| init_cycles | input | 16 | Length of the initialization interval |
| settle_cycles | input | 16 | Length of the closed-loop settle interval |
| cmp_lo | input | 1 | Comparator: control voltage below selected level |
| cmp_hi | input | 1 | Comparator: control voltage above selected level |
| level_sel | output | 11 | One-hot reference level select |
| cp_break | output | 1 | High opens the charge-pump loop |
| band_code | output | 3 | Oscillator sub-band code to the current DAC |
| locked | output | 1 | Search has found the window |
| out_of_range | output | 1 | Search stopped at a code limit |

## Verification
On every cycle the assertions check several properties: that the select stays one-hot and advances bit by bit, that the loop is open whenever a level is selected, and that the code moves by at most one step and only as the loop closes. They also check that power-down holds everything at zero, that the code is steady while locked, and that lock and out-of-range are exclusive. Some behaviour is shown only by the bench's scenarios: the exact lengths of the init and settle intervals, the direction of each step against the window bits, the rise-over-fall priority, the masking of the other nine steps, saturation at both ends, restart from the held code, and resumption after an aborted search.

// File: rtl/bsc_pkg.sv
// Shared types for the band search controller.
// Assumes: one state register in the top; encodings are free to change.
package bsc_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_INIT   = 3'd1,
        ST_SWEEP  = 3'd2,
        ST_DECIDE = 3'd3,
        ST_SETTLE = 3'd4,
        ST_LOCK   = 3'd5,
        ST_OOR    = 3'd6
    } bsc_state_t;

endpackage

// File: rtl/bsc_timer.sv
// Loadable down-counter for the init and settle intervals.
// Assumes: load has priority over counting; zero is combinational from the count.
module bsc_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && !zero)
            cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/bsc_sweep.sv
// Walks a one-hot level select over NLEV steps and latches the window comparisons.
// Assumes: active is high for exactly the walk; the step index returns to zero when idle.
module bsc_sweep #(
    parameter int NLEV   = 11,
    parameter int LO_IDX = 2,
    parameter int HI_IDX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            cmp_lo,
    input  logic            cmp_hi,
    output logic [NLEV-1:0] level_sel,
    output logic            last,
    output logic            above,
    output logic            below
);

    localparam int IW = (NLEV > 1) ? $clog2(NLEV) : 1;

    logic [IW-1:0] idx_q;

    assign last = (idx_q == IW'(NLEV - 1));

    // Decode the step index into one select line per reference level.
    for (genvar i = 0; i < NLEV; i++) begin : g_dec
        assign level_sel[i] = active && (idx_q == IW'(i));
    end

    // Advance one level per cycle while walking; park at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            idx_q <= '0;
        else if (!last)
            idx_q <= idx_q + 1'b1;
    end

    // Latch the low-side comparison at the low window step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            below <= 1'b0;
        else if (active && idx_q == IW'(LO_IDX))
            below <= cmp_lo;
    end

    // Latch the high-side comparison at the high window step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            above <= 1'b0;
        else if (active && idx_q == IW'(HI_IDX))
            above <= cmp_hi;
    end

endmodule

// File: rtl/bsc_band.sv
// Holds the band code and applies a single saturating step per update.
// Assumes: up and down are never both asserted by the caller.
module bsc_band #(
    parameter int BW       = 3,
    parameter int BAND_RST = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          up,
    input  logic          down,
    output logic [BW-1:0] band_q,
    output logic          sat
);

    localparam logic [BW-1:0] BAND_MAX = {BW{1'b1}};

    assign sat = (up && band_q == BAND_MAX) || (down && band_q == '0);

    // Step the code by one unless the request would leave the range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            band_q <= BW'(BAND_RST);
        else if (upd && !sat) begin
            if (up)
                band_q <= band_q + 1'b1;
            else if (down)
                band_q <= band_q - 1'b1;
        end
    end

endmodule

// File: rtl/band_sel_ctrl.sv
// Sub-band search controller: opens the loop, walks the reference levels,
// steps the band code from the window result, and closes the loop to settle.
// Assumes: comparators respond within the cycle a level is selected.
module band_sel_ctrl #(
    parameter int NLEV     = 11,
    parameter int LO_IDX   = 2,
    parameter int HI_IDX   = 8,
    parameter int BW       = 3,
    parameter int CW       = 16,
    parameter int BAND_RST = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_dn,
    input  logic            start,
    input  logic [CW-1:0]   init_cycles,
    input  logic [CW-1:0]   settle_cycles,
    input  logic            cmp_lo,
    input  logic            cmp_hi,
    output logic [NLEV-1:0] level_sel,
    output logic            cp_break,
    output logic [BW-1:0]   band_code,
    output logic            locked,
    output logic            out_of_range
);

    import bsc_pkg::*;

    bsc_state_t    state_q, state_d;
    logic          tmr_load, tmr_run, tmr_zero;
    logic [CW-1:0] tmr_val;
    logic          sw_last, sw_above, sw_below;
    logic          step_up, step_dn, band_sat;
    logic [BW-1:0] band_q;

    assign step_up = sw_above;
    assign step_dn = sw_below && !sw_above;

    bsc_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .zero     (tmr_zero)
    );

    bsc_sweep #(.NLEV(NLEV), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_SWEEP),
        .cmp_lo    (cmp_lo),
        .cmp_hi    (cmp_hi),
        .level_sel (level_sel),
        .last      (sw_last),
        .above     (sw_above),
        .below     (sw_below)
    );

    bsc_band #(.BW(BW), .BAND_RST(BAND_RST)) u_band (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (state_q == ST_DECIDE),
        .up     (step_up),
        .down   (step_dn),
        .band_q (band_q),
        .sat    (band_sat)
    );

    // Next-state selection; power-down overrides every state.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = init_cycles;
        tmr_run  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                state_d  = ST_INIT;
                tmr_load = 1'b1;
            end
            ST_INIT: begin
                tmr_run = 1'b1;
                if (tmr_zero) state_d = ST_SWEEP;
            end
            ST_SWEEP: begin
                if (sw_last) state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (!step_up && !step_dn)
                    state_d = ST_LOCK;
                else if (band_sat)
                    state_d = ST_OOR;
                else begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = settle_cycles;
                end
            end
            ST_SETTLE: begin
                tmr_run = 1'b1;
                if (tmr_zero) state_d = ST_SWEEP;
            end
            ST_LOCK, ST_OOR: begin
                if (start) state_d = ST_SWEEP;
            end
            default: state_d = ST_OFF;
        endcase
        if (pwr_dn) begin
            state_d  = ST_OFF;
            tmr_load = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    assign cp_break     = (state_q == ST_SWEEP) || (state_q == ST_DECIDE);
    assign locked       = (state_q == ST_LOCK);
    assign out_of_range = (state_q == ST_OOR);
    assign band_code    = pwr_dn ? '0 : band_q;

endmodule

// File: rtl/bsc_checker.sv
// Cycle-by-cycle properties of the band search controller, bound to its ports.
// Assumes: ports only; a one-cycle flag guards every look into the past.
module bsc_checker #(
    parameter int NLEV = 11,
    parameter int BW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_dn,
    input logic [NLEV-1:0] level_sel,
    input logic            cp_break,
    input logic [BW-1:0]   band_code,
    input logic            locked,
    input logic            out_of_range
);

    logic seen;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        seen <= rst_n;
    end

    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(level_sel));

    p_sel_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_sel != '0) |-> cp_break);

    p_sel_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_sel != '0 && !level_sel[NLEV-1] && !pwr_dn) |=>
        (level_sel == ($past(level_sel) << 1)));

    p_pdn_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && pwr_dn && $past(pwr_dn)) |->
        (band_code == '0 && !cp_break && level_sel == '0 && !locked && !out_of_range));

    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !pwr_dn && $past(!pwr_dn)) |->
        (band_code == $past(band_code) || band_code == $past(band_code) + 1'b1 ||
         band_code == $past(band_code) - 1'b1));

    p_change_at_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !pwr_dn && $past(!pwr_dn) && band_code != $past(band_code)) |->
        $fell(cp_break));

    p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!cp_break && level_sel == '0));

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && locked && $past(locked) && !pwr_dn) |-> $stable(band_code));

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && out_of_range));

    p_oor_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> !cp_break);

endmodule

bind band_sel_ctrl bsc_checker #(.NLEV(NLEV), .BW(BW)) u_bsc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_dn       (pwr_dn),
    .level_sel    (level_sel),
    .cp_break     (cp_break),
    .band_code    (band_code),
    .locked       (locked),
    .out_of_range (out_of_range)
);

// File: tb/tb_band_sel_ctrl.sv
// Directed bench: a behavioural control-voltage and comparator model closes the loop.
module tb_band_sel_ctrl;

    logic        clk = 1'b0;
    logic        rst_n, pwr_dn, start, cmp_lo, cmp_hi;
    logic [15:0] init_cycles, settle_cycles;
    logic [10:0] level_sel;
    logic        cp_break, locked, out_of_range;
    logic [2:0]  band_code;

    int checks = 0;
    int fails  = 0;
    int target = 3;
    logic ovr_both = 1'b0;
    logic glitch   = 1'b0;
    int vctr;

    always #10 clk = ~clk;

    band_sel_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .start(start),
        .init_cycles(init_cycles), .settle_cycles(settle_cycles),
        .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .level_sel(level_sel),
        .cp_break(cp_break), .band_code(band_code), .locked(locked),
        .out_of_range(out_of_range)
    );

    // Control voltage: 50 inside the window, 35 per band away from target.
    always_comb vctr = 50 + (target - int'(band_code)) * 35;

    // Level i of the ladder sits at 10*i; window is levels 2 (20) and 8 (80).
    always_comb begin
        cmp_hi = 1'b0;
        cmp_lo = 1'b0;
        for (int i = 0; i < 11; i++) begin
            if (level_sel[i]) begin
                cmp_hi = (vctr > i * 10);
                cmp_lo = (vctr < i * 10);
                if (ovr_both && i == 8) cmp_hi = 1'b1;
                if (ovr_both && i == 2) cmp_lo = 1'b1;
                if (glitch && i == 9)   cmp_hi = 1'b1;
                if (glitch && i == 1)   cmp_lo = 1'b1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 3000; k++) begin
            if (locked || out_of_range) break;
            @(negedge clk);
        end
    endtask

    // Counts negedges from now until cp_break is first seen high.
    task automatic count_to_break(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cp_break && n < 200);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pwr_dn = 1'b1; start = 1'b0;
        init_cycles = 16'd5; settle_cycles = 16'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset band_code", int'(band_code), 0);
        check("R1 reset cp_break", int'(cp_break), 0);
        check("R1 reset level_sel", int'(level_sel), 0);
        check("R1 reset flags", int'(locked) + int'(out_of_range), 0);
    endtask

    task automatic t_init_walk();
        int n;
        target = 3;
        pwr_dn = 1'b0;
        count_to_break(n);
        check("R2 init interval length", n, 5 + 2);
        check("R3 walk starts at bit 0", int'(level_sel), 1);
        for (int i = 1; i < 11; i++) begin
            @(negedge clk);
            check("R3 walk bit", int'(level_sel), 1 << i);
        end
        @(negedge clk);
        check("R3 decision cycle break", int'(cp_break), 1);
        check("R3 decision cycle select", int'(level_sel), 0);
        @(negedge clk);
        check("R7 locked after inside walk", int'(locked), 1);
        check("R7 loop closed when locked", int'(cp_break), 0);
        check("R11 reset band code held", int'(band_code), 3);
    endtask

    // Tracks a search: band step sizes and closed-loop run lengths.
    task automatic track(output int changes, output int bad_step, output int bad_settle);
        int prev, low_run;
        prev = int'(band_code); low_run = 0;
        changes = 0; bad_step = 0; bad_settle = 0;
        for (int k = 0; k < 3000; k++) begin
            if (locked || out_of_range) break;
            if (int'(band_code) != prev) begin
                changes++;
                if (int'(band_code) - prev != 1 && prev - int'(band_code) != 1) bad_step++;
                prev = int'(band_code);
            end
            if (!cp_break) low_run++;
            else begin
                if (low_run != 0 && low_run != int'(settle_cycles) + 1) bad_settle++;
                low_run = 0;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_step_up();
        int ch, bs, bt;
        target = 6;
        pulse_start();
        check("R9 restart opens loop", int'(cp_break), 1);
        check("R9 restart walk at bit 0", int'(level_sel), 1);
        check("R9 restart clears lock", int'(locked), 0);
        check("R9 restart keeps code", int'(band_code), 3);
        track(ch, bs, bt);
        check("R4 upward step count", ch, 3);
        check("R4 single steps upward", bs, 0);
        check("R6 settle length", bt, 0);
        check("R7 lock at band 6", int'(locked) * 8 + int'(band_code), 8 + 6);
    endtask

    task automatic t_step_down();
        int ch, bs, bt;
        target = 1;
        pulse_start();
        track(ch, bs, bt);
        check("R4 downward step count", ch, 5);
        check("R4 single steps downward", bs, 0);
        check("R6 settle length downward", bt, 0);
        check("R7 lock at band 1", int'(locked) * 8 + int'(band_code), 8 + 1);
    endtask

    task automatic t_priority();
        ovr_both = 1'b1;
        pulse_start();
        while (cp_break) @(negedge clk);
        check("R4 rise wins over fall", int'(band_code), 2);
        ovr_both = 1'b0;
        wait_done();
        check("R4 returns to band 1", int'(locked) * 8 + int'(band_code), 8 + 1);
    endtask

    task automatic t_mask();
        glitch = 1'b1;
        pulse_start();
        for (int k = 0; k < 12; k++) @(negedge clk);
        check("R5 other steps ignored: locked", int'(locked), 1);
        check("R5 other steps ignored: band", int'(band_code), 1);
        glitch = 1'b0;
    endtask

    task automatic t_saturate();
        int highs = 0;
        target = 9;
        pulse_start();
        wait_done();
        check("R8 top saturation flag", int'(out_of_range), 1);
        check("R8 top saturation code", int'(band_code), 7);
        check("R8 no lock with range flag", int'(locked), 0);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (cp_break) highs++;
        end
        check("R8 no walk after stop", highs, 0);
        target = -3;
        pulse_start();
        check("R9 restart from range stop", int'(out_of_range) * 2 + int'(cp_break), 1);
        wait_done();
        check("R8 bottom saturation", int'(out_of_range) * 8 + int'(band_code), 8 + 0);
        target = 4;
        pulse_start();
        wait_done();
        check("R9 relock from range stop", int'(locked) * 8 + int'(band_code), 8 + 4);
    endtask

    task automatic t_abort();
        int n;
        target = 0;
        pulse_start();
        repeat (3) @(negedge clk);
        pwr_dn = 1'b1;
        #1;
        check("R1 code gated at once", int'(band_code), 0);
        @(negedge clk);
        check("R10 abort closes loop", int'(cp_break), 0);
        check("R10 abort clears select", int'(level_sel), 0);
        repeat (4) @(negedge clk);
        check("R1 held in power-down", int'(band_code) + int'(locked) + int'(cp_break), 0);
        init_cycles = 16'd2;
        pwr_dn = 1'b0;
        count_to_break(n);
        check("R2 init after release", n, 2 + 2);
        check("R10 resumes from kept code", int'(band_code), 4);
        wait_done();
        check("R10 search completes at 0", int'(locked) * 8 + int'(band_code), 8 + 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_init_walk();
        t_step_up();
        t_step_down();
        t_priority();
        t_mask();
        t_saturate();
        t_abort();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule